// File: doc/BRIEF.md
# Floppy Head Positioning Stepper

This block moves the read/write head of a floppy drive across the disc surface. It drives a step strobe and a direction level, and keeps its own copy of the track under the head. A seek command moves the head to a target track, one strobe per track. A restore command walks the head outward until the drive reports track zero, then zeroes the track copy. A restore also runs by itself as soon as reset is released.

Step timing is set by a two-bit rate select that picks one of four parameter intervals. A test-mode input replaces that interval with a much shorter one. Each operation ends with a one-cycle completion pulse. A restore that never finds track zero ends with an error flag.

Top module: `head_stepper`

## Requirements
- R1: When reset is released, a restore starts without any command. The restore steps outward until `trk0_n` is low, then sets `cur_track` to 0 and pulses `done`.
- R2: `dirc` is 1 while stepping toward increasing track numbers (toward the disc centre). It is 0 while stepping toward decreasing numbers and during every restore. `dirc` does not change while `step` is high.
- R3: A seek produces exactly |target − cur_track| step pulses. `cur_track` moves by one per pulse, at the falling edge of that pulse, and equals the target when `done` rises.
- R4: Each step pulse is high for PULSE_W clocks. Consecutive rising edges of `step` within one operation are PULSE_W + RATEn clocks apart, where n is the value of `rate_sel` (0..3).
- R5: While `test_mode` is 1, the spacing between rising edges becomes PULSE_W + TEST_RATE clocks, whatever `rate_sel` is.
- R6: `done` is high for exactly one clock at the end of each operation. A seek to the current track produces no step pulse and still pulses `done`.
- R7: If MAX_RESTORE pulses go out during a restore without `trk0_n` going low, the restore stops. At that point `done` and `restore_err` rise together and `cur_track` keeps its value. `restore_err` clears when the next command is accepted.
- R8: `seek_go` and `restore_go` are ignored while an operation is in progress. The running operation finishes unchanged.
- R9: If `seek_go` and `restore_go` arrive in the same idle cycle, the restore is carried out and the seek is dropped.
- R10: While `rst_n` is low, `step`, `dirc`, `done` and `restore_err` are 0 and `cur_track` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seek_go | input | 1 | Start a seek to `target` (one-cycle strobe) |
| restore_go | input | 1 | Start a restore (one-cycle strobe) |
| target | input | TRACK_W | Destination track for a seek |
| trk0_n | input | 1 | Track-zero sensor, active low |
| test_mode | input | 1 | Selects the fast test step rate |
| rate_sel | input | 2 | Step interval select |
| step | output | 1 | Step strobe to the drive |
| dirc | output | 1 | Direction: 1 toward centre, 0 outward |
| cur_track | output | TRACK_W | Current track number |
| done | output | 1 | One-cycle end-of-operation pulse |
| restore_err | output | 1 | Restore ended without finding track zero |

## Verification
The two functions that can land in the same cycle are the two command starts, and a command start with an operation already running. The bench provokes the first by raising `seek_go` and `restore_go` in one idle cycle. It judges the outcome by the pulse direction, the pulse count against its own head model, and a final `cur_track` of 0. It provokes the second by sending a new seek and a restore in the middle of a seek. The check is that the pulse count and the final track still match the first target, and that no further pulses follow.

// File: rtl/hs_pkg.sv
package hs_pkg;
   typedef enum logic [2:0] {
      ST_BOOT,
      ST_IDLE,
      ST_CMP,
      ST_RCHK,
      ST_PULSE,
      ST_GAP
   } hs_state_e;

   typedef enum logic {
      OP_SEEK,
      OP_RESTORE
   } hs_op_e;

   typedef struct packed {
      logic inc;
      logic dec;
      logic clr;
   } hs_trk_cmd_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else        q <= {q[STAGES-2+1-1:0], din} ;
         end
         assign dout = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hs_step_timer.sv
module hs_step_timer #(
   parameter int PULSE_W   = 3,
   parameter int RATE0     = 6,
   parameter int RATE1     = 10,
   parameter int RATE2     = 16,
   parameter int RATE3     = 24,
   parameter int TEST_RATE = 2,
   parameter bit TEST_EN   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_pulse,
   input  logic       load_gap,
   input  logic [1:0] rate_sel,
   input  logic       test_mode,
   output logic       expired
);
   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int MAXV  = max_of(max_of(max_of(RATE0, RATE1), max_of(RATE2, RATE3)),
                                 max_of(PULSE_W, TEST_RATE));
   localparam int CNT_W = $clog2(MAXV + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] sel_rate;
   logic [CNT_W-1:0] gap_len;

   always_comb begin
      unique case (rate_sel)
         2'd0:    sel_rate = CNT_W'(RATE0);
         2'd1:    sel_rate = CNT_W'(RATE1);
         2'd2:    sel_rate = CNT_W'(RATE2);
         default: sel_rate = CNT_W'(RATE3);
      endcase
   end

   generate
      if (TEST_EN) begin : g_test
         assign gap_len = (test_mode ? CNT_W'(TEST_RATE) : sel_rate) - CNT_W'(1);
      end else begin : g_notest
         assign gap_len = sel_rate - CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (load_pulse)      cnt <= CNT_W'(PULSE_W);
      else if (load_gap)        cnt <= gap_len;
      else if (cnt != '0)       cnt <= cnt - CNT_W'(1);
   end

   assign expired = (cnt == CNT_W'(1));

   AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_pulse, load_gap})); // R4
   AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |=> (cnt == CNT_W'(PULSE_W))); // R4
endmodule

// File: rtl/hs_track_reg.sv
module hs_track_reg
   import hs_pkg::*;
#(
   parameter int TRACK_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  hs_trk_cmd_t        cmd,
   output logic [TRACK_W-1:0] track
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       track <= '0;
      else if (cmd.clr) track <= '0;
      else if (cmd.inc) track <= track + TRACK_W'(1);
      else if (cmd.dec) track <= track - TRACK_W'(1);
   end

   AST_TRACK_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (track != $past(track)) |-> (track == $past(track) + TRACK_W'(1) ||
                                   track == $past(track) - TRACK_W'(1) ||
                                   track == '0)); // R3
endmodule

// File: rtl/hs_step_seq.sv
module hs_step_seq
   import hs_pkg::*;
#(
   parameter int TRACK_W     = 8,
   parameter int MAX_RESTORE = 255
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               seek_go,
   input  logic               restore_go,
   input  logic [TRACK_W-1:0] target,
   input  logic [TRACK_W-1:0] cur_track,
   input  logic               trk0_n,
   input  logic               expired,
   output logic               load_pulse,
   output logic               load_gap,
   output hs_trk_cmd_t        trk_cmd,
   output logic               step,
   output logic               dirc,
   output logic               done,
   output logic               err
);
   localparam int STEPS_W = $clog2(MAX_RESTORE + 1);

   hs_state_e          state;
   hs_op_e             op;
   logic [TRACK_W-1:0] tgt_q;
   logic [STEPS_W-1:0] steps_q;
   logic               dir_q, done_q, err_q;
   logic               at_max;

   assign at_max = (steps_q == STEPS_W'(MAX_RESTORE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_BOOT;
         op      <= OP_RESTORE;
         tgt_q   <= '0;
         steps_q <= '0;
         dir_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_BOOT: begin
               op      <= OP_RESTORE;
               steps_q <= '0;
               err_q   <= 1'b0;
               state   <= ST_RCHK;
            end
            ST_IDLE: begin
               if (restore_go) begin
                  op      <= OP_RESTORE;
                  steps_q <= '0;
                  err_q   <= 1'b0;
                  state   <= ST_RCHK;
               end else if (seek_go) begin
                  op    <= OP_SEEK;
                  tgt_q <= target;
                  err_q <= 1'b0;
                  state <= ST_CMP;
               end
            end
            ST_CMP: begin
               if (cur_track == tgt_q) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  dir_q <= (tgt_q > cur_track);
                  state <= ST_PULSE;
               end
            end
            ST_RCHK: begin
               dir_q <= 1'b0;
               if (!trk0_n) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else if (at_max) begin
                  err_q  <= 1'b1;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  state <= ST_PULSE;
               end
            end
            ST_PULSE: begin
               if (expired) begin
                  state <= ST_GAP;
                  if (op == OP_RESTORE) steps_q <= steps_q + STEPS_W'(1);
               end
            end
            ST_GAP: begin
               if (expired) state <= (op == OP_SEEK) ? ST_CMP : ST_RCHK;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      load_pulse  = ((state == ST_CMP) && (cur_track != tgt_q)) ||
                    ((state == ST_RCHK) && trk0_n && !at_max);
      load_gap    = (state == ST_PULSE) && expired;
      trk_cmd.inc = load_gap && (op == OP_SEEK) && dir_q;
      trk_cmd.dec = load_gap && (op == OP_SEEK) && !dir_q;
      trk_cmd.clr = (state == ST_RCHK) && !trk0_n;
   end

   assign step = (state == ST_PULSE);
   assign dirc = dir_q;
   assign done = done_q;
   assign err  = err_q;

   AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && $past(step)) |-> $stable(dirc)); // R2
   AST_RESTORE_OUTWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && op == OP_RESTORE) |-> !dirc); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done); // R7
   AST_SEEK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op == OP_SEEK) |-> (cur_track == tgt_q)); // R3
   AST_ZERO_ON_SENSOR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RCHK && !trk0_n) |=> (cur_track == '0)); // R1
   AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PULSE && !expired) |=> (state == ST_PULSE)); // R8
endmodule

// File: rtl/head_stepper.sv
module head_stepper
   import hs_pkg::*;
#(
   parameter int TRACK_W     = 8,
   parameter int PULSE_W     = 3,
   parameter int RATE0       = 6,
   parameter int RATE1       = 10,
   parameter int RATE2       = 16,
   parameter int RATE3       = 24,
   parameter int TEST_RATE   = 2,
   parameter bit TEST_EN     = 1'b1,
   parameter int MAX_RESTORE = 255,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               seek_go,
   input  logic               restore_go,
   input  logic [TRACK_W-1:0] target,
   input  logic               trk0_n,
   input  logic               test_mode,
   input  logic [1:0]         rate_sel,
   output logic               step,
   output logic               dirc,
   output logic [TRACK_W-1:0] cur_track,
   output logic               done,
   output logic               restore_err
);
   localparam int MIN_RATE = (TEST_RATE < RATE0) ? TEST_RATE : RATE0;

   generate
      if (TRACK_W < 1 || TRACK_W > 16) begin : g_bad_width
         $error("head_stepper: TRACK_W out of range");
      end
      if (PULSE_W < 1) begin : g_bad_pulse
         $error("head_stepper: PULSE_W must be at least 1");
      end
      if (RATE0 < 2 || RATE1 < 2 || RATE2 < 2 || RATE3 < 2 || TEST_RATE < 2) begin : g_bad_rate
         $error("head_stepper: every interval must be at least 2");
      end
      if (MAX_RESTORE < 1) begin : g_bad_max
         $error("head_stepper: MAX_RESTORE must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4 || PULSE_W + MIN_RATE - 1 <= SYNC_STAGES) begin : g_bad_sync
         $error("head_stepper: sensor synchroniser too deep for the step timing");
      end
   endgenerate

   logic        trk0_s;
   logic        expired, load_pulse, load_gap;
   hs_trk_cmd_t trk_cmd;

   hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (trk0_n),
      .dout (trk0_s)
   );

   hs_step_timer #(
      .PULSE_W  (PULSE_W),
      .RATE0    (RATE0),
      .RATE1    (RATE1),
      .RATE2    (RATE2),
      .RATE3    (RATE3),
      .TEST_RATE(TEST_RATE),
      .TEST_EN  (TEST_EN)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_pulse(load_pulse),
      .load_gap  (load_gap),
      .rate_sel  (rate_sel),
      .test_mode (test_mode),
      .expired   (expired)
   );

   hs_track_reg #(.TRACK_W(TRACK_W)) u_track (
      .clk  (clk),
      .rst_n(rst_n),
      .cmd  (trk_cmd),
      .track(cur_track)
   );

   hs_step_seq #(
      .TRACK_W    (TRACK_W),
      .MAX_RESTORE(MAX_RESTORE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .seek_go   (seek_go),
      .restore_go(restore_go),
      .target    (target),
      .cur_track (cur_track),
      .trk0_n    (trk0_s),
      .expired   (expired),
      .load_pulse(load_pulse),
      .load_gap  (load_gap),
      .trk_cmd   (trk_cmd),
      .step      (step),
      .dirc      (dirc),
      .done      (done),
      .err       (restore_err)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!step && !dirc && !done && !restore_err && cur_track == '0)); // R10
endmodule

// File: tb/sim_head_stepper.sv
module sim_head_stepper;
   localparam int CLK_PERIOD = 10;
   localparam int PW   = 3;
   localparam int RT0  = 6;
   localparam int RT1  = 10;
   localparam int RT2  = 16;
   localparam int RT3  = 24;
   localparam int TRT  = 2;
   localparam int MAXR = 255;
   localparam int NVEC = 6;
   // each vector: target[10:3], rate_sel[2:1], test_mode[0]
   localparam logic [10:0] VEC [NVEC] = '{
      {8'd40,  2'd0, 1'b0},
      {8'd25,  2'd1, 1'b0},
      {8'd25,  2'd2, 1'b0},
      {8'd200, 2'd3, 1'b0},
      {8'd3,   2'd2, 1'b1},
      {8'd4,   2'd0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       seek_go = 1'b0;
   logic       restore_go = 1'b0;
   logic [7:0] target = '0;
   logic       test_mode = 1'b0;
   logic [1:0] rate_sel = 2'd0;
   logic       force_off = 1'b0;
   logic       trk0_n;
   logic       step, dirc, done, restore_err;
   logic [7:0] cur_track;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int epoch = 0;
   int exp_period = PW + RT0;
   logic exp_dir = 1'b0;

   // drive and monitor model state (written only by the monitor)
   int head = 5;
   int pulses = 0;
   int period_bad = 0;
   int dir_bad = 0;
   int width_bad = 0;
   int done_bad = 0;
   int hi_cnt = 0;
   int last_rise = 0;
   int rise_epoch = -1;
   logic prev_step = 1'b0;
   logic prev_done = 1'b0;

   assign trk0_n = force_off ? 1'b1 : (head != 0);

   head_stepper #(
      .TRACK_W(8), .PULSE_W(PW), .RATE0(RT0), .RATE1(RT1), .RATE2(RT2), .RATE3(RT3),
      .TEST_RATE(TRT), .TEST_EN(1'b1), .MAX_RESTORE(MAXR), .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .seek_go(seek_go), .restore_go(restore_go),
      .target(target), .trk0_n(trk0_n), .test_mode(test_mode), .rate_sel(rate_sel),
      .step(step), .dirc(dirc), .cur_track(cur_track), .done(done),
      .restore_err(restore_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (step && !prev_step) begin
            pulses <= pulses + 1;
            head <= dirc ? head + 1 : head - 1;
            if (dirc !== exp_dir) dir_bad <= dir_bad + 1;
            if (rise_epoch == epoch && (cyc - last_rise) != exp_period)
               period_bad <= period_bad + 1;
            last_rise <= cyc;
            rise_epoch <= epoch;
         end
         if (step) hi_cnt <= (prev_step ? hi_cnt : 0) + 1;
         if (!step && prev_step && hi_cnt != PW) width_bad <= width_bad + 1;
         if (done && prev_done) done_bad <= done_bad + 1;
      end
      prev_step <= step;
      prev_done <= done;
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic set_rate(input logic [1:0] rs, input logic tm);
      rate_sel = rs;
      test_mode = tm;
      if (tm) exp_period = PW + TRT;
      else case (rs)
         2'd0: exp_period = PW + RT0;
         2'd1: exp_period = PW + RT1;
         2'd2: exp_period = PW + RT2;
         default: exp_period = PW + RT3;
      endcase
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic pulse_cmd(input bit sk, input bit rs, input logic [7:0] tg);
      @(negedge clk);
      epoch++;
      target = tg;
      seek_go = sk;
      restore_go = rs;
      @(negedge clk);
      seek_go = 1'b0;
      restore_go = 1'b0;
   endtask

   task automatic run_all();
      int cur;
      int p0, pb0, db0, wb0, dn0;
      // R10: outputs in reset
      repeat (3) @(negedge clk);
      check(step == 0 && dirc == 0 && done == 0 && restore_err == 0, "R10 reset outputs",
            {step, dirc, done, restore_err}, 0);
      check(cur_track == 0, "R10 reset track", cur_track, 0);
      // R1: automatic restore from head at track 5
      set_rate(2'd0, 1'b0);
      exp_dir = 1'b0;
      epoch++;
      rst_n = 1'b1;
      wait_done();
      check(pulses == 5, "R1 restore pulse count", pulses, 5);
      check(cur_track == 0 && head == 0, "R1 restore track", cur_track, 0);
      check(dir_bad == 0, "R2 restore direction outward", dir_bad, 0);
      check(period_bad == 0 && width_bad == 0, "R4 restore step timing", period_bad + width_bad, 0);
      cur = 0;
      // table walk of seeks
      for (int i = 0; i < NVEC; i++) begin
         int tg, np;
         tg = int'(VEC[i][10:3]);
         np = (tg > cur) ? tg - cur : cur - tg;
         set_rate(VEC[i][2:1], VEC[i][0]);
         exp_dir = (tg > cur);
         p0 = pulses; pb0 = period_bad; db0 = dir_bad; wb0 = width_bad;
         pulse_cmd(1'b1, 1'b0, 8'(tg));
         wait_done();
         check(pulses - p0 == np, "R3 seek pulse count", pulses - p0, np);
         check(cur_track == 8'(tg) && head == tg, "R3 seek landing track", cur_track, tg);
         check(dir_bad == db0, "R2 seek direction", dir_bad - db0, 0);
         check(period_bad == pb0 && width_bad == wb0,
               VEC[i][0] ? "R5 test-mode step spacing" : "R4 step spacing and width",
               (period_bad - pb0) + (width_bad - wb0), 0);
         if (np == 0) check(1'b1 && done, "R6 zero-distance seek done", done, 1);
         cur = tg;
      end
      check(done_bad == 0, "R6 done one cycle", done_bad, 0);
      // R8: commands during a running seek are ignored
      set_rate(2'd0, 1'b0);
      exp_dir = 1'b1;
      p0 = pulses;
      pulse_cmd(1'b1, 1'b0, 8'd10);
      repeat (12) @(negedge clk);
      target = 8'd100; seek_go = 1'b1; restore_go = 1'b1;
      @(negedge clk);
      seek_go = 1'b0; restore_go = 1'b0;
      wait_done();
      check(pulses - p0 == 6 && cur_track == 10, "R8 busy commands ignored", cur_track, 10);
      p0 = pulses;
      repeat (60) @(negedge clk);
      check(pulses == p0 && cur_track == 10, "R8 no later activity", pulses - p0, 0);
      // R9: seek and restore in the same idle cycle
      exp_dir = 1'b0;
      p0 = pulses; db0 = dir_bad;
      pulse_cmd(1'b1, 1'b1, 8'd50);
      wait_done();
      check(pulses - p0 == 10 && dir_bad == db0, "R9 restore wins pulses", pulses - p0, 10);
      check(cur_track == 0 && head == 0, "R9 restore wins track", cur_track, 0);
      // R7: restore without track zero
      set_rate(2'd1, 1'b1);
      exp_dir = 1'b1;
      pulse_cmd(1'b1, 1'b0, 8'd7);
      wait_done();
      check(cur_track == 7, "R3 seek before error test", cur_track, 7);
      exp_dir = 1'b0;
      force_off = 1'b1;
      p0 = pulses; pb0 = period_bad;
      pulse_cmd(1'b0, 1'b1, 8'd0);
      while (!done) begin
         @(negedge clk);
         if (!done && restore_err) check(1'b0, "R7 error before done", 1, 0);
      end
      check(restore_err == 1, "R7 error flag with done", restore_err, 1);
      check(pulses - p0 == MAXR, "R7 restore pulse limit", pulses - p0, MAXR);
      check(cur_track == 7, "R7 track kept", cur_track, 7);
      check(period_bad == pb0, "R5 test rate ignores rate_sel", period_bad - pb0, 0);
      @(negedge clk);
      check(restore_err == 1, "R7 error held", restore_err, 1);
      pulse_cmd(1'b1, 1'b0, 8'd7);
      check(restore_err == 0, "R7 error cleared by command", restore_err, 0);
      wait_done();
      check(done_bad == 0, "R6 done one cycle overall", done_bad, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (200000) @(posedge clk);
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule